// File: doc/BRIEF.md
# Keyed Byte-Stream Chaining Scrambler

This block scrambles a continuous stream of bytes under a fixed 24-bit key and accepts one byte on every clock cycle. The key is split into three bytes: K2 (bits 23:16), K1 (bits 15:8) and K0 (bits 7:0). Each output byte is formed from three parts. The first is an unsigned comparison of the current input byte against K2. The second is the previous input byte XORed with K1. The third is a chaining term taken from earlier output bytes, or from a key byte while the stream is still young.

A stream starts either after reset or at a start-of-stream pulse that arrives together with a valid byte. The first and second bytes of a stream follow their own rules. From the third byte onward, the comparison selects between the previous output and the output two bytes back. Every result is registered and leaves the block one clock after its input byte, with a valid flag that follows the input strobe.

Top module: `byte_chain_scrambler`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid and out_byte are 0. After reset, the next valid byte is treated as byte 1 of a stream.
- R2: out_valid equals in_valid from the previous cycle. The result for a byte accepted at a clock edge is present on out_byte from that edge until the next edge.
- R3: The selection condition, called "hit", is in_byte >= key[23:16] compared as unsigned. Equality counts as a hit.
- R4: Byte 1 of a stream gives in_byte XOR K2 on a hit and in_byte XOR K1 otherwise.
- R5: Byte 2 gives (previous input byte XOR K1) XOR the byte-1 output on a hit, and (previous input byte XOR K1) XOR K0 otherwise.
- R6: Byte 3 and every later byte give (previous input byte XOR K1) XOR the previous output on a hit, and (previous input byte XOR K1) XOR the output two bytes back otherwise.
- R7: A cycle with in_valid low does not advance the stream, and out_byte keeps its last value. The next valid byte continues from the same position in the stream.
- R8: in_sos high together with in_valid makes that byte byte 1 of a new stream. in_sos high while in_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_sos | input | 1 | The presented byte starts a new stream |
| in_byte | input | 8 | Plain input byte |
| key | input | 24 | Scrambling key, held constant |
| out_valid | output | 1 | out_byte holds a new result |
| out_byte | output | 8 | Scrambled byte, registered |

## Verification
A wrong stream position or a wrong history register shows up at the ports within one or two valid bytes. A stale previous-input register corrupts the very next output. A wrong last-output register corrupts the next hit byte. A wrong older-output register corrupts the next miss byte from byte 3 onward. For this reason the stimulus mixes hits, misses and the exact K2 value right after every restart and around idle gaps, so that each history term is observed on the earliest byte that consumes it.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_LATER  = 2'd2
  } phase_e;
endpackage

// File: rtl/scr_phase_ctr.sv
module scr_phase_ctr
  import scr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  input  logic   restart,
  output phase_e phase
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      if (restart)             cnt <= CNT_ONE;
      else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
    end
  end

  always_comb begin
    if (restart || cnt == '0) phase = PH_FIRST;
    else if (cnt == CNT_ONE)  phase = PH_SECOND;
    else                      phase = PH_LATER;
  end

  // R7: idle cycles leave the stream position untouched
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));
  // R8: a restart with a valid byte makes the next byte the second
  assert_restart_pos_R8: assert property (@(posedge clk) disable iff (rst)
    (adv && restart) |=> (cnt == CNT_ONE));
  // R6: once a byte is accepted the position never reads as "no bytes"
  assert_cnt_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt != '0));
endmodule

// File: rtl/scr_history.sv
module scr_history #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clear,
  input  logic [W-1:0] cur_in,
  input  logic [W-1:0] cur_out,
  output logic [W-1:0] prev_in,
  output logic [W-1:0] last_out,
  output logic [W-1:0] prior_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_in   <= '0;
      last_out  <= '0;
      prior_out <= '0;
    end else if (adv) begin
      prev_in   <= cur_in;
      last_out  <= cur_out;
      prior_out <= clear ? '0 : last_out;
    end
  end

  // R7: history is frozen while no byte is offered
  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(prev_in) && $stable(last_out) && $stable(prior_out)));
  // R6: the older output slot receives what the newer slot held
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear) |=> (prior_out == $past(last_out)));
endmodule

// File: rtl/scr_mix.sv
module scr_mix
  import scr_pkg::*;
#(
  parameter int W = 8
) (
  input  phase_e         phase,
  input  logic [W-1:0]   cur_in,
  input  logic [3*W-1:0] key,
  input  logic [W-1:0]   prev_in,
  input  logic [W-1:0]   last_out,
  input  logic [W-1:0]   prior_out,
  output logic [W-1:0]   mixed
);
  logic [W-1:0] k_hi, k_mid, k_lo, masked_prev, chain;
  logic         hit;

  assign k_hi        = key[3*W-1 -: W];
  assign k_mid       = key[2*W-1 -: W];
  assign k_lo        = key[W-1:0];
  assign hit         = (cur_in >= k_hi);
  assign masked_prev = prev_in ^ k_mid;

  always_comb begin
    unique case (phase)
      PH_FIRST:  chain = hit ? k_hi : k_mid;
      PH_SECOND: chain = masked_prev ^ (hit ? last_out : k_lo);
      default:   chain = masked_prev ^ (hit ? last_out : prior_out);
    endcase
    mixed = (phase == PH_FIRST) ? (cur_in ^ chain) : chain;
  end
endmodule

// File: rtl/byte_chain_scrambler.sv
module byte_chain_scrambler
  import scr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_sos,
  input  logic [DATA_W-1:0]   in_byte,
  input  logic [3*DATA_W-1:0] key,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_byte
);
  localparam int KEY_W = 3 * DATA_W;

  phase_e            phase;
  logic              restart;
  logic [DATA_W-1:0] prev_in, last_out, prior_out, mixed;

  assign restart = in_valid && in_sos;

  scr_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(in_valid), .restart(restart), .phase(phase)
  );

  scr_history #(.W(DATA_W)) u_hist (
    .clk(clk), .rst(rst), .adv(in_valid), .clear(restart),
    .cur_in(in_byte), .cur_out(mixed),
    .prev_in(prev_in), .last_out(last_out), .prior_out(prior_out)
  );

  scr_mix #(.W(DATA_W)) u_mix (
    .phase(phase), .cur_in(in_byte), .key(key), .prev_in(prev_in),
    .last_out(last_out), .prior_out(prior_out), .mixed(mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_byte <= mixed;
    end
  end

  // R2: valid flag is the input strobe one cycle late
  assert_valid_lag_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (out_valid == $past(in_valid)));
  // R7: output byte holds across idle cycles
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_byte));
  // R4: first byte of a restarted stream, hit case (R3 equality included)
  assert_first_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (restart && in_byte >= key[KEY_W-1 -: DATA_W])
      |=> (out_byte == ($past(in_byte) ^ $past(key[KEY_W-1 -: DATA_W]))));
  // R4: first byte of a restarted stream, miss case
  assert_first_miss_R4: assert property (@(posedge clk) disable iff (rst)
    (restart && in_byte < key[KEY_W-1 -: DATA_W])
      |=> (out_byte == ($past(in_byte) ^ $past(key[2*DATA_W-1 -: DATA_W]))));
endmodule

// File: tb/byte_chain_scrambler_bench.sv
`timescale 1ns/1ps
module byte_chain_scrambler_bench;
  localparam logic [23:0] KEY = 24'h80_5A_C3;
  localparam logic [7:0]  K2 = KEY[23:16], K1 = KEY[15:8], K0 = KEY[7:0];
  localparam int NV = 22;
  // stimulus entries: {valid, sos, data}
  localparam logic [9:0] VEC [0:NV-1] = '{
    {2'b10, 8'h80}, {2'b10, 8'h7F}, {2'b10, 8'hFF}, {2'b10, 8'h00},
    {2'b10, 8'h81}, {2'b00, 8'h55}, {2'b10, 8'h3C}, {2'b10, 8'h80},
    {2'b11, 8'h10}, {2'b10, 8'h80}, {2'b10, 8'h01}, {2'b10, 8'hA5},
    {2'b11, 8'hC0}, {2'b10, 8'h7F}, {2'b00, 8'h00}, {2'b00, 8'hFF},
    {2'b10, 8'h22}, {2'b10, 8'hEE}, {2'b10, 8'h80}, {2'b10, 8'h7F},
    {2'b10, 8'h90}, {2'b10, 8'h11}
  };

  logic       clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_sos = 1'b0;
  logic [7:0] in_byte = '0, out_byte;
  logic       out_valid;
  int         tests = 0, fails = 0;
  bit         done = 1'b0;

  // reference state
  int         m_cnt = 0;
  logic [7:0] m_prev = '0, m_o1 = '0, m_o2 = '0, exp_out = '0;
  logic       exp_v = 1'b0;
  string      exp_tag = "R1";

  always #4 clk = ~clk;

  byte_chain_scrambler u_byte_chain_scrambler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sos(in_sos),
    .in_byte(in_byte), .key(KEY), .out_valid(out_valid), .out_byte(out_byte)
  );

  task automatic model(input logic v, input logic s, input logic [7:0] d);
    logic first, hit;
    logic [7:0] e;
    if (!v) begin
      exp_v = 1'b0; exp_tag = "R7";
      return;
    end
    first = s || (m_cnt == 0);
    hit   = (d >= K2);
    if (first) begin
      e = hit ? (d ^ K2) : (d ^ K1); exp_tag = s ? "R8" : "R4";
    end else if (m_cnt == 1) begin
      e = (m_prev ^ K1) ^ (hit ? m_o1 : K0); exp_tag = "R5";
    end else begin
      e = (m_prev ^ K1) ^ (hit ? m_o1 : m_o2); exp_tag = "R6";
    end
    if (d == K2) exp_tag = {exp_tag, "/R3"};
    m_o2  = first ? 8'h00 : m_o1;
    m_o1  = e;
    m_prev = d;
    m_cnt = first ? 1 : ((m_cnt >= 3) ? 3 : m_cnt + 1);
    exp_out = e; exp_v = 1'b1;
  endtask

  task automatic check(input string tag, input logic av, input logic [7:0] ab,
                       input logic ev, input logic [7:0] eb);
    tests++;
    if (av !== ev || ab !== eb) begin
      fails++;
      $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
               tag, av, ab, ev, eb);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d);
    in_valid = v; in_sos = s; in_byte = d;
    model(v, s, d);
    @(posedge clk);
    @(negedge clk);
    check(exp_tag, out_valid, out_byte, exp_v, exp_out);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_sos = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 during reset", out_valid, out_byte, 1'b0, 8'h00);
    rst = 1'b0;
    m_cnt = 0; m_prev = '0; m_o1 = '0; m_o2 = '0; exp_out = '0;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", out_valid, out_byte, 1'b0, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // table walk
    for (int i = 0; i < NV; i++) step(VEC[i][9], VEC[i][8], VEC[i][7:0]);
    // R8: sos without valid is ignored, stream continues
    step(1'b0, 1'b1, 8'h44);
    step(1'b1, 1'b0, 8'h05);
    step(1'b1, 1'b0, 8'hF0);
    // R1: reset mid-stream, next byte is byte 1 (miss then exact K2 hit)
    do_reset();
    step(1'b1, 1'b0, 8'h7F);
    step(1'b1, 1'b0, K2);
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'hFE);
    // R2: back-to-back restarts
    step(1'b1, 1'b1, K2);
    step(1'b1, 1'b1, 8'h01);
    step(1'b0, 1'b0, 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule